// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of one DMA channel. It owns the remaining-byte counter and decides when the channel moves a data beat. A beat can be started by a hardware request line, but only while the request enable is set. A beat can also be started by a one-cycle software start pulse. In cycle-steal mode each trigger moves exactly one beat. In continuous mode a single trigger runs beats back to back until the counter reaches zero. The datapath itself and address generation sit outside. The sequencer only offers beats on a valid/ready handshake, and the datapath answers each beat with either a clean completion or a bus error that names the failing side.

The block keeps a status word with these flags: done, busy, request pending, source error, destination error and configuration error. It can raise an interrupt while done is set. It also drives two one-cycle link pulses that trigger other channels. A 2-bit link mode decides whether those pulses follow every cycle-steal beat or the moment the count reaches zero. When auto-stop is set, the request enable clears itself at the end of a transfer, so a request line that stays high does not start another one.

Back-pressure rule: `beat_valid` stays high until the datapath returns `beat_ready`. `beat_err` and `beat_err_dst` are only looked at in the cycle where valid and ready are both high. The configuration inputs must be held stable while `st_busy` is high.

Top module: `dma_chan_seq`

## Requirements
- R1: With `cfg_cycle_steal`=1, each trigger produces exactly one beat, after which the channel goes idle with `st_busy`=0 until the next trigger.
- R2: With `cfg_cycle_steal`=0, one trigger keeps issuing beats until the count reaches zero. Each clean beat lowers `bcr_out` by the beat size: code 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes. If the remaining count is smaller than the beat size, the count goes to 0.
- R3: A trigger is `sw_start`=1, or `hw_req`=1 while `req_en`=1. Triggers only act while the channel is idle, and `hw_req` has no effect while `req_en`=0.
- R4: Link mode 0 gives no pulses. Mode 1 pulses `link1_pulse` after every cycle-steal beat and pulses `link2_pulse` when the count reaches zero. Mode 2 pulses `link1_pulse` after every cycle-steal beat. Mode 3 pulses `link1_pulse` only when the count reaches zero. Each pulse lasts one cycle and appears in the cycle after the beat completes.
- R5: With `cfg_auto_stop`=1, `req_en` clears when the count reaches zero. With `cfg_auto_stop`=0 it keeps its value.
- R6: After reset all flags, `irq`, `req_en`, `bcr_out` and `beat_valid` are 0. `st_done` sets when the count reaches zero, and `st_busy` is high exactly while a beat sequence is in progress.
- R7: A `done_clr` pulse clears `st_done` and all three error flags.
- R8: `irq` is high exactly while `st_done`=1 and `cfg_int_en`=1.
- R9: A beat that completes with `beat_err`=1 stops the channel and sets `st_done`. It sets `st_err_dst` if `beat_err_dst`=1 and `st_err_src` otherwise. That beat does not change `bcr_out`.
- R10: A trigger while the count is 0, or while `cfg_beat_size`=3, sets `st_err_cfg` and `st_done` and issues no beat.
- R11: `beat_valid` holds until it is accepted. A `bcr_wr` while `st_busy`=1 is ignored.
- R12: `st_req` is high while `hw_req`=1 and `req_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cycle_steal | input | 1 | 1: one beat per trigger; 0: run until the count is zero |
| cfg_auto_stop | input | 1 | Clear the request enable when the count reaches zero |
| cfg_int_en | input | 1 | Interrupt enable |
| cfg_link_mode | input | 2 | Link pulse mode 0..3 |
| cfg_beat_size | input | 2 | Beat size code: 0 = 4 bytes, 1 = 1 byte, 2 = 2 bytes, 3 = invalid |
| bcr_wr | input | 1 | Load the byte counter (only while idle) |
| bcr_wdata | input | 24 | Byte count value to load |
| req_en_wr | input | 1 | Write the request enable |
| req_en_wdata | input | 1 | Request enable value to write |
| hw_req | input | 1 | Hardware request line |
| sw_start | input | 1 | Software start pulse |
| done_clr | input | 1 | Clear done and the error flags |
| beat_valid | output | 1 | A beat is offered to the datapath |
| beat_ready | input | 1 | The datapath completes the beat |
| beat_err | input | 1 | The completing beat ended with a bus error |
| beat_err_dst | input | 1 | Error side: 1 = destination, 0 = source |
| bcr_out | output | 24 | Bytes still to transfer |
| req_en | output | 1 | Hardware request enable |
| st_done | output | 1 | Done flag |
| st_busy | output | 1 | Busy flag |
| st_req | output | 1 | Request pending flag |
| st_err_src | output | 1 | Source bus error flag |
| st_err_dst | output | 1 | Destination bus error flag |
| st_err_cfg | output | 1 | Configuration error flag |
| irq | output | 1 | Interrupt |
| link1_pulse | output | 1 | Link request to the first secondary channel |
| link2_pulse | output | 1 | Link request to the second secondary channel |

## Verification
If the state register is wrong, the fault shows within one cycle: `beat_valid` and `st_busy` either drop while beats are still owed or stay high after the count is zero. A fault in the counter or its zero detector shows as an extra or a missing beat, and as a `st_done` or link pulse that arrives one beat early or late. The bench catches these by comparing the counts of handshakes and pulses against the length computed from the configured count and beat size. A wrong flag update shows at once on `st_done`, `irq` or the error bits in the cycle after the completing beat.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    LINK_NONE       = 2'd0,
    LINK_BEAT_ZERO2 = 2'd1,
    LINK_BEAT       = 2'd2,
    LINK_ZERO       = 2'd3
  } link_mode_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_BAD  = 2'd3
  } beat_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned FLAG_DONE = 0;
  localparam int unsigned FLAG_SRC  = 1;
  localparam int unsigned FLAG_DST  = 2;
  localparam int unsigned FLAG_CFG  = 3;
  localparam int unsigned N_FLAGS   = 4;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_bcr.sv
module dma_seq_bcr #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic [2:0]       dec_bytes,
  output logic [CNT_W-1:0] cnt,
  output logic             is_zero,
  output logic             next_zero
);

  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] after_dec;

  assign step      = CNT_W'(dec_bytes);
  assign after_dec = (cnt <= step) ? '0 : cnt - step;
  assign is_zero   = (cnt == '0);
  assign next_zero = (after_dec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (dec) begin
      cnt <= after_dec;
    end else if (load) begin
      cnt <= load_val;
    end
  end

endmodule

// File: rtl/dma_seq_link.sv
module dma_seq_link
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat_done,
  input  logic       hit_zero,
  input  logic       cycle_steal,
  input  logic [1:0] mode,
  output logic       link1,
  output logic       link2
);

  logic per_beat;
  logic fire1;
  logic fire2;

  assign per_beat = cycle_steal && (mode == LINK_BEAT_ZERO2 || mode == LINK_BEAT);
  assign fire1    = beat_done && (per_beat || (hit_zero && mode == LINK_ZERO));
  assign fire2    = beat_done && hit_zero && (mode == LINK_BEAT_ZERO2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link1 <= 1'b0;
      link2 <= 1'b0;
    end else begin
      link1 <= fire1;
      link2 <= fire2;
    end
  end

endmodule

// File: rtl/dma_seq_status.sv
module dma_seq_status #(
  parameter int unsigned NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NF-1:0] set,
  output logic [NF-1:0] flags
);

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[g] <= 1'b0;
      end else if (set[g]) begin
        flags[g] <= 1'b1;
      end else if (clr) begin
        flags[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cycle_steal,
  input  logic             cfg_auto_stop,
  input  logic             cfg_int_en,
  input  logic [1:0]       cfg_link_mode,
  input  logic [1:0]       cfg_beat_size,
  input  logic             bcr_wr,
  input  logic [CNT_W-1:0] bcr_wdata,
  input  logic             req_en_wr,
  input  logic             req_en_wdata,
  input  logic             hw_req,
  input  logic             sw_start,
  input  logic             done_clr,
  output logic             beat_valid,
  input  logic             beat_ready,
  input  logic             beat_err,
  input  logic             beat_err_dst,
  output logic [CNT_W-1:0] bcr_out,
  output logic             req_en,
  output logic             st_done,
  output logic             st_busy,
  output logic             st_req,
  output logic             st_err_src,
  output logic             st_err_dst,
  output logic             st_err_cfg,
  output logic             irq,
  output logic             link1_pulse,
  output logic             link2_pulse
);

  seq_state_e     state_q;
  seq_state_e     state_d;
  logic           idle;
  logic           trigger;
  logic           cfg_bad;
  logic           start_ok;
  logic           cfg_fail;
  logic           accept;
  logic           beat_fail;
  logic           beat_ok;
  logic           last_beat;
  logic           cnt_zero;
  logic           cnt_next_zero;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_q;

  assign idle     = (state_q == ST_IDLE);
  assign trigger  = idle && (sw_start || (req_en && hw_req));
  assign cfg_bad  = cnt_zero || (cfg_beat_size == SZ_BAD);
  assign start_ok = trigger && !cfg_bad;
  assign cfg_fail = trigger && cfg_bad;

  assign beat_valid = (state_q == ST_RUN);
  assign accept     = beat_valid && beat_ready;
  assign beat_fail  = accept && beat_err;
  assign beat_ok    = accept && !beat_err;
  assign last_beat  = beat_ok && cnt_next_zero;

  always_comb begin
    state_d = state_q;
    if (idle) begin
      if (start_ok) state_d = ST_RUN;
    end else if (beat_fail || last_beat || (beat_ok && cfg_cycle_steal)) begin
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_en  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_en_wr) begin
        req_en <= req_en_wdata;
      end else if (last_beat && cfg_auto_stop) begin
        req_en <= 1'b0;
      end
    end
  end

  dma_seq_bcr #(.CNT_W(CNT_W)) i_bcr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (bcr_wr && idle),
    .load_val  (bcr_wdata),
    .dec       (beat_ok),
    .dec_bytes (size_bytes(cfg_beat_size)),
    .cnt       (bcr_out),
    .is_zero   (cnt_zero),
    .next_zero (cnt_next_zero)
  );

  dma_seq_link i_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_done   (beat_ok),
    .hit_zero    (cnt_next_zero),
    .cycle_steal (cfg_cycle_steal),
    .mode        (cfg_link_mode),
    .link1       (link1_pulse),
    .link2       (link2_pulse)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_DONE] = last_beat || beat_fail || cfg_fail;
    flag_set[FLAG_SRC]  = beat_fail && !beat_err_dst;
    flag_set[FLAG_DST]  = beat_fail && beat_err_dst;
    flag_set[FLAG_CFG]  = cfg_fail;
  end

  dma_seq_status #(.NF(N_FLAGS)) i_status (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (done_clr),
    .set   (flag_set),
    .flags (flag_q)
  );

  assign st_done    = flag_q[FLAG_DONE];
  assign st_err_src = flag_q[FLAG_SRC];
  assign st_err_dst = flag_q[FLAG_DST];
  assign st_err_cfg = flag_q[FLAG_CFG];
  assign st_busy    = beat_valid;
  assign st_req     = hw_req && req_en;
  assign irq        = st_done && cfg_int_en;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic             beat_err,
  input logic [CNT_W-1:0] bcr_out,
  input logic             st_busy,
  input logic             st_done,
  input logic             st_err_cfg,
  input logic             irq,
  input logic             link1_pulse,
  input logic             link2_pulse
);

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid); // R11

  AST_BCR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |=> bcr_out <= $past(bcr_out)); // R2

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_done); // R8

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_err |=> !beat_valid && st_done); // R9

  AST_CFG_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err_cfg) |-> !beat_valid); // R10

  AST_LINK1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    link1_pulse |=> !link1_pulse); // R4

  AST_LINK2_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    link2_pulse |-> bcr_out == '0); // R4

endmodule

bind dma_chan_seq dma_seq_chk #(.CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .beat_valid  (beat_valid),
  .beat_ready  (beat_ready),
  .beat_err    (beat_err),
  .bcr_out     (bcr_out),
  .st_busy     (st_busy),
  .st_done     (st_done),
  .st_err_cfg  (st_err_cfg),
  .irq         (irq),
  .link1_pulse (link1_pulse),
  .link2_pulse (link2_pulse)
);

// File: tb/test_dma_chan_seq.sv
`timescale 1ns/1ps
module test_dma_chan_seq;

  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cycle_steal = 0, cfg_auto_stop = 0, cfg_int_en = 0;
  logic [1:0] cfg_link_mode = 0, cfg_beat_size = 0;
  logic bcr_wr = 0;
  logic [CW-1:0] bcr_wdata = 0;
  logic req_en_wr = 0, req_en_wdata = 0, hw_req = 0, sw_start = 0, done_clr = 0;
  logic beat_ready = 0, beat_err = 0, beat_err_dst = 0;
  logic beat_valid, req_en, st_done, st_busy, st_req;
  logic st_err_src, st_err_dst, st_err_cfg, irq, link1_pulse, link2_pulse;
  logic [CW-1:0] bcr_out;

  int checks = 0;
  int failures = 0;
  int beats = 0, l1 = 0, l2 = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_chan_seq i_dma_chan_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbytes(input int code);
    return (code == 1) ? 1 : (code == 2) ? 2 : 4;
  endfunction

  function automatic int exp_beats(input int cnt, input int code);
    return (cnt + nbytes(code) - 1) / nbytes(code);
  endfunction

  function automatic int exp_l1(input int nb, input int cs, input int lm);
    if ((lm == 1 || lm == 2) && cs != 0) return nb;
    return (lm == 3) ? 1 : 0;
  endfunction

  // Called at a negedge; returns at a negedge n cycles later.
  task automatic observe(input int n);
    repeat (n) begin
      #1;
      if (beat_valid && beat_ready) beats++;
      if (link1_pulse) l1++;
      if (link2_pulse) l2++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int cs, input int as, input int lm, input int sz,
                       input int ie, input int cnt);
    cfg_cycle_steal = cs[0]; cfg_auto_stop = as[0]; cfg_link_mode = lm[1:0];
    cfg_beat_size = sz[1:0]; cfg_int_en = ie[0];
    bcr_wr = 1; bcr_wdata = CW'(cnt);
    @(negedge clk);
    bcr_wr = 0;
    beats = 0; l1 = 0; l2 = 0;
  endtask

  task automatic clear_done();
    done_clr = 1;
    @(negedge clk);
    done_clr = 0;
    req_en_wr = 1; req_en_wdata = 0;
    @(negedge clk);
    req_en_wr = 0;
  endtask

  task automatic run_random(input int cnt, input int sz, input int cs,
                            input int lm, input int as, input int ie);
    int nb;
    setup(cs, as, lm, sz, ie, cnt);
    req_en_wr = 1; req_en_wdata = 1;
    @(negedge clk);
    req_en_wr = 0;
    hw_req = 1;
    for (int i = 0; i < 3000; i++) begin
      if (link1_pulse) l1++;
      if (link2_pulse) l2++;
      if (st_done) break;
      beat_ready = $urandom_range(0, 1);
      #1;
      if (beat_valid && beat_ready) beats++;
      @(negedge clk);
    end
    hw_req = 0; beat_ready = 0;
    nb = exp_beats(cnt, sz);
    chk(cs ? "R1 cycle-steal beat count" : "R2 continuous beat count", beats, nb);
    chk("R2 count ends at zero", int'(bcr_out), 0);
    chk("R4 link1 pulses", l1, exp_l1(nb, cs, lm));
    chk("R4 link2 pulses", l2, (lm == 1) ? 1 : 0);
    chk("R6 done at zero", st_done, 1);
    chk("R6 idle after zero", st_busy, 0);
    chk("R8 irq follows enable", irq, ie);
    chk("R5 auto-stop request enable", req_en, as ? 0 : 1);
    observe(3);
    chk("R10 no config error after clean run", st_err_cfg, 0);
    clear_done();
    chk("R7 done cleared", st_done, 0);
    chk("R8 irq low after clear", irq, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset busy", st_busy, 0);
    chk("R6 reset done", st_done, 0);
    chk("R6 reset count", int'(bcr_out), 0);
    chk("R6 reset valid", beat_valid, 0);
    chk("R6 reset irq", irq, 0);
    chk("R6 reset req_en", req_en, 0);

    // R3 / R12: hw_req gated by req_en
    setup(1, 0, 0, 1, 0, 8);
    hw_req = 1; beat_ready = 1;
    observe(5);
    chk("R3 hw_req ignored while disabled", beats, 0);
    chk("R3 count untouched", int'(bcr_out), 8);
    chk("R12 request flag low while disabled", st_req, 0);
    hw_req = 0;
    req_en_wr = 1; req_en_wdata = 1;
    @(negedge clk);
    req_en_wr = 0; hw_req = 1;
    #1;
    chk("R12 request flag", st_req, 1);
    hw_req = 0;
    req_en_wr = 1; req_en_wdata = 0;
    @(negedge clk);
    req_en_wr = 0;

    // R1: one software start, one beat
    beats = 0;
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    observe(6);
    chk("R1 single beat per start", beats, 1);
    chk("R1 count after one beat", int'(bcr_out), 7);
    chk("R1 busy low between triggers", st_busy, 0);
    chk("R1 not done yet", st_done, 0);
    beat_ready = 0;

    // R11: hold valid, ignore load while busy, then finish
    setup(0, 0, 3, 1, 1, 10);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    observe(4);
    chk("R11 valid held without ready", beat_valid, 1);
    bcr_wr = 1; bcr_wdata = 99;
    @(negedge clk);
    bcr_wr = 0;
    chk("R11 load ignored while busy", int'(bcr_out), 10);
    beat_ready = 1;
    observe(12);
    beat_ready = 0;
    chk("R2 continuous run length", beats, 10);
    chk("R4 mode 3 single link1", l1, 1);
    chk("R6 done after run", st_done, 1);
    chk("R8 irq with enable", irq, 1);
    clear_done();

    // R9: destination error on the third beat
    setup(0, 0, 0, 1, 0, 16);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0; beat_ready = 1;
    @(negedge clk);
    @(negedge clk);
    beat_err = 1; beat_err_dst = 1;
    @(negedge clk);
    beat_err = 0; beat_ready = 0;
    chk("R9 dst error flag", st_err_dst, 1);
    chk("R9 src flag clear", st_err_src, 0);
    chk("R9 done on error", st_done, 1);
    chk("R9 stopped", beat_valid, 0);
    chk("R9 errored beat not counted", int'(bcr_out), 14);
    clear_done();
    chk("R7 error flag cleared", st_err_dst, 0);

    // R9: source error on the first beat
    sw_start = 1;
    @(negedge clk);
    sw_start = 0; beat_ready = 1; beat_err = 1; beat_err_dst = 0;
    @(negedge clk);
    beat_err = 0; beat_ready = 0;
    chk("R9 src error flag", st_err_src, 1);
    chk("R9 count unchanged", int'(bcr_out), 14);
    clear_done();
    chk("R7 src flag cleared", st_err_src, 0);

    // R10: zero count and invalid size
    setup(0, 0, 0, 1, 0, 0);
    sw_start = 1; beat_ready = 1;
    @(negedge clk);
    sw_start = 0;
    #1;
    chk("R10 zero count flags config", st_err_cfg, 1);
    chk("R10 zero count no beat", beat_valid, 0);
    chk("R10 done on config error", st_done, 1);
    beat_ready = 0;
    clear_done();
    chk("R7 config flag cleared", st_err_cfg, 0);
    setup(0, 0, 0, 3, 0, 5);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    #1;
    chk("R10 bad size flags config", st_err_cfg, 1);
    chk("R10 bad size count kept", int'(bcr_out), 5);
    @(negedge clk);
    clear_done();

    // Directed corner: remainder smaller than beat size
    run_random(5, 0, 0, 1, 1, 1);
    run_random(1, 2, 1, 2, 0, 0);
    for (int t = 0; t < 30; t++) begin
      run_random(1 + $urandom_range(0, 39), $urandom_range(0, 2), $urandom_range(0, 1),
                 $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule